// File: doc/BRIEF.md
# Reconfigurable Region Controller with Accelerator Memory Guard

This block is the fixed control logic that sits beside a set of reconfigurable accelerator regions. Software reaches each region through a register page of its own on a simple control bus. Through that page it moves the region between idle and busy. It loads the one memory window the region's current client allows. It binds one line from a shared pool of processor interrupt lines to the region, and later frees that line.

Each region's accelerator issues burst requests toward a high-throughput memory port. The block checks every burst, start address and full length, against the region's window. A burst that fits the window of a busy region passes straight through to the port. Any other burst is stopped before the port and answered with an error strobe. The refusal is also recorded in a sticky violation bit, which drives the region's bound interrupt line while it stays set.

The window registers accept writes only while the region is idle. A new client's window can therefore be loaded between two uses of the region, but never while an accelerator is running.

Top module: `region_ctrl`

## Requirements
- R1: A control bus address selects region `cfg_addr[CFG_AW-1:12]`, so each region owns one 4 KB page. Word `cfg_addr[4:2]` selects the register in that page: 0 = control/status, 1 = window base, 2 = window size, 3 = interrupt. A write to one region's page leaves every other region's registers unchanged.
- R2: After reset every region is idle. Base and size read 0. No violation is recorded, no interrupt line is bound, and `irq_out` is all zero.
- R3: Writing control with bit 0 set moves an idle region to busy. Writing control with bit 1 set moves the region to idle, and bit 1 wins if both are set. Status read bit 0 shows busy.
- R4: Writes to the base or size register of a busy region are ignored. The previous window stays in force.
- R5: A burst of `len+1` beats of `BEAT_BYTES` bytes each, starting at `addr`, is allowed only if all three hold: the region is busy, `addr >= base`, and `addr + (len+1)*BEAT_BYTES <= base + size`. The whole burst is checked, not only its first beat.
- R6: A refused burst never raises `mem_req`, and `acc_err` is high in the same cycle. The region's sticky violation flag (status bit 1) is set at the next clock edge. A control write with bit 2 set clears the flag.
- R7: An interrupt-register write with bit 0 set binds the lowest-numbered free line to an unbound region. The interrupt read shows bit 0 = bound and bits [11:8] = line number. No line is ever bound to two regions.
- R8: If no line is free, an allocation binds nothing and sets the none-free flag (interrupt read bit 1). The flag clears on the next successful allocation or release.
- R9: An interrupt-register write with bit 1 set unbinds the region's line. A later allocation can then reuse that line.
- R10: `irq_out[k]` is high exactly while the region bound to line k has its violation flag set.
- R11: An allowed burst drives `mem_req`, `mem_addr` and `mem_len` from the accelerator's request, and `acc_gnt` follows `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control bus write strobe |
| cfg_addr | input | CFG_AW | Control bus byte address (region page + register word) |
| cfg_wdata | input | 32 | Control bus write data |
| cfg_rdata | output | 32 | Control bus read data for `cfg_addr` (combinational) |
| acc_req | input | N_REGIONS | Burst request from each region's accelerator |
| acc_addr | input | N_REGIONS*ADDR_W | Burst start byte address, per region |
| acc_len | input | N_REGIONS*LEN_W | Burst length minus one in beats, per region |
| acc_gnt | output | N_REGIONS | Grant returned to each accelerator |
| acc_err | output | N_REGIONS | Refusal strobe returned to each accelerator |
| mem_req | output | N_REGIONS | Request toward the memory port, per region |
| mem_addr | output | N_REGIONS*ADDR_W | Burst start address toward the memory port |
| mem_len | output | N_REGIONS*LEN_W | Burst length toward the memory port |
| mem_gnt | input | N_REGIONS | Grant from the memory port, per region |
| irq_out | output | IRQ_LINES | Interrupt lines toward the processor |

## Verification
The hardest state to reach from the ports is an exhausted interrupt pool. To get there, every line must be bound and one more region must still ask for a line. The bench shrinks the pool to three lines so that four regions can exhaust it. It then releases a middle line to check that the allocator reuses the hole and does not take the next higher number. The window edge cases are driven with bursts whose last byte lands exactly on the limit and one beat beyond it. The frozen-window case is reached by loading the base while the region is busy and reading it back.

// File: rtl/region_ctrl_pkg.sv
package region_ctrl_pkg;
   localparam int PAGE_BITS = 12;
   localparam logic [2:0] W_CTRL = 3'd0;
   localparam logic [2:0] W_BASE = 3'd1;
   localparam logic [2:0] W_SIZE = 3'd2;
   localparam logic [2:0] W_IRQ  = 3'd3;
   localparam int CTRL_START   = 0;
   localparam int CTRL_FINISH  = 1;
   localparam int CTRL_CLRVIOL = 2;
   localparam int IRQ_ALLOC    = 0;
   localparam int IRQ_RELEASE  = 1;
endpackage

// File: rtl/region_guard.sv
module region_guard #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 4,
   parameter int BEAT_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              load_base,
   input  logic              load_size,
   input  logic [ADDR_W-1:0] wdata,
   input  logic              clr_viol,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic              allowed,
   output logic              err,
   output logic              viol,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] size_o
);
   localparam int SHIFT = $clog2(BEAT_BYTES);

   if ((1 << SHIFT) != BEAT_BYTES) begin : g_bad_beat
      $error("BEAT_BYTES must be a power of two");
   end

   logic [ADDR_W-1:0] base_q, size_q;
   logic              viol_q;
   logic [ADDR_W:0]   span_w, end_w, limit_w;
   logic              in_win;

   assign span_w  = (ADDR_W+1)'({1'b0, len} + (LEN_W+1)'(1)) << SHIFT;
   assign end_w   = {1'b0, addr} + span_w;
   assign limit_w = {1'b0, base_q} + {1'b0, size_q};
   assign in_win  = (addr >= base_q) && (end_w <= limit_w);

   assign allowed = req & busy & in_win;
   assign err     = req & ~(busy & in_win);
   assign viol    = viol_q;
   assign base_o  = base_q;
   assign size_o  = size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
         viol_q <= 1'b0;
      end else begin
         if (load_base && !busy) base_q <= wdata;
         if (load_size && !busy) size_q <= wdata;
         if (err)           viol_q <= 1'b1;
         else if (clr_viol) viol_q <= 1'b0;
      end
   end
endmodule

// File: rtl/region_irq_pool.sv
module region_irq_pool #(
   parameter int N_REGIONS = 4,
   parameter int IRQ_LINES = 16,
   parameter int RIDX_W    = 2,
   parameter int LIW       = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc,
   input  logic                     release_line,
   input  logic [RIDX_W-1:0]        sel,
   input  logic [N_REGIONS-1:0]     viol,
   output logic [N_REGIONS-1:0]     bound,
   output logic [N_REGIONS-1:0]     none_free,
   output logic [N_REGIONS*LIW-1:0] line_flat,
   output logic [IRQ_LINES-1:0]     irq_out
);
   logic [N_REGIONS-1:0] bound_q, nf_q;
   logic [LIW-1:0]       line_q [N_REGIONS];
   logic [IRQ_LINES-1:0] used;
   logic [LIW-1:0]       pick;
   logic                 any_free;

   always_comb begin
      used = '0;
      for (int l = 0; l < IRQ_LINES; l++)
         for (int r = 0; r < N_REGIONS; r++)
            if (bound_q[r] && line_q[r] == LIW'(l)) used[l] = 1'b1;
      pick     = '0;
      any_free = 1'b0;
      for (int l = IRQ_LINES-1; l >= 0; l--)
         if (!used[l]) begin
            pick     = LIW'(l);
            any_free = 1'b1;
         end
   end

   always_comb begin
      irq_out = '0;
      for (int l = 0; l < IRQ_LINES; l++)
         for (int r = 0; r < N_REGIONS; r++)
            if (bound_q[r] && viol[r] && line_q[r] == LIW'(l)) irq_out[l] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bound_q <= '0;
         nf_q    <= '0;
         for (int r = 0; r < N_REGIONS; r++) line_q[r] <= '0;
      end else if (release_line) begin
         bound_q[sel] <= 1'b0;
         nf_q[sel]    <= 1'b0;
      end else if (alloc && !bound_q[sel]) begin
         if (any_free) begin
            bound_q[sel] <= 1'b1;
            line_q[sel]  <= pick;
            nf_q[sel]    <= 1'b0;
         end else begin
            nf_q[sel]    <= 1'b1;
         end
      end
   end

   assign bound     = bound_q;
   assign none_free = nf_q;
   for (genvar r = 0; r < N_REGIONS; r++) begin : g_line
      assign line_flat[r*LIW +: LIW] = line_q[r];
   end
endmodule

// File: rtl/region_ctrl.sv
module region_ctrl
   import region_ctrl_pkg::*;
#(
   parameter int N_REGIONS  = 4,
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 4,
   parameter int BEAT_BYTES = 4,
   parameter int IRQ_LINES  = 16,
   localparam int RIDX_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1,
   localparam int CFG_AW    = PAGE_BITS + RIDX_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_wr,
   input  logic [CFG_AW-1:0]           cfg_addr,
   input  logic [31:0]                 cfg_wdata,
   output logic [31:0]                 cfg_rdata,
   input  logic [N_REGIONS-1:0]        acc_req,
   input  logic [N_REGIONS*ADDR_W-1:0] acc_addr,
   input  logic [N_REGIONS*LEN_W-1:0]  acc_len,
   output logic [N_REGIONS-1:0]        acc_gnt,
   output logic [N_REGIONS-1:0]        acc_err,
   output logic [N_REGIONS-1:0]        mem_req,
   output logic [N_REGIONS*ADDR_W-1:0] mem_addr,
   output logic [N_REGIONS*LEN_W-1:0]  mem_len,
   input  logic [N_REGIONS-1:0]        mem_gnt,
   output logic [IRQ_LINES-1:0]        irq_out
);
   localparam int LIW = (IRQ_LINES > 1) ? $clog2(IRQ_LINES) : 1;

   if (IRQ_LINES < 1 || IRQ_LINES > 16) begin : g_bad_lines
      $error("IRQ_LINES must be 1..16");
   end
   if (ADDR_W > 32 || ADDR_W < PAGE_BITS) begin : g_bad_aw
      $error("ADDR_W must be 12..32");
   end

   logic [RIDX_W-1:0]           sel;
   logic [2:0]                  word;
   logic                        hit;
   logic [N_REGIONS-1:0]        busy_q, viol_w, allowed_w, bound_w, nf_w;
   logic [N_REGIONS*ADDR_W-1:0] base_flat, size_flat;
   logic [N_REGIONS*LIW-1:0]    line_flat;

   assign sel  = cfg_addr[CFG_AW-1:PAGE_BITS];
   assign word = cfg_addr[4:2];
   assign hit  = ({1'b0, sel} < (RIDX_W+1)'(N_REGIONS));

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
      logic me_wr;
      assign me_wr = cfg_wr && hit && (sel == RIDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q[r] <= 1'b0;
         else if (me_wr && word == W_CTRL) begin
            if (cfg_wdata[CTRL_FINISH])     busy_q[r] <= 1'b0;
            else if (cfg_wdata[CTRL_START]) busy_q[r] <= 1'b1;
         end
      end

      region_guard #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_guard (
         .clk       (clk),
         .rst_n     (rst_n),
         .busy      (busy_q[r]),
         .load_base (me_wr && word == W_BASE),
         .load_size (me_wr && word == W_SIZE),
         .wdata     (cfg_wdata[ADDR_W-1:0]),
         .clr_viol  (me_wr && word == W_CTRL && cfg_wdata[CTRL_CLRVIOL]),
         .req       (acc_req[r]),
         .addr      (acc_addr[r*ADDR_W +: ADDR_W]),
         .len       (acc_len[r*LEN_W +: LEN_W]),
         .allowed   (allowed_w[r]),
         .err       (acc_err[r]),
         .viol      (viol_w[r]),
         .base_o    (base_flat[r*ADDR_W +: ADDR_W]),
         .size_o    (size_flat[r*ADDR_W +: ADDR_W])
      );

      assign mem_req[r]                     = allowed_w[r];
      assign acc_gnt[r]                     = allowed_w[r] & mem_gnt[r];
      assign mem_addr[r*ADDR_W +: ADDR_W]   = acc_addr[r*ADDR_W +: ADDR_W];
      assign mem_len[r*LEN_W +: LEN_W]      = acc_len[r*LEN_W +: LEN_W];
   end

   region_irq_pool #(.N_REGIONS(N_REGIONS), .IRQ_LINES(IRQ_LINES), .RIDX_W(RIDX_W), .LIW(LIW)) u_pool (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc        (cfg_wr && hit && word == W_IRQ && cfg_wdata[IRQ_ALLOC]),
      .release_line (cfg_wr && hit && word == W_IRQ && cfg_wdata[IRQ_RELEASE]),
      .sel          (sel),
      .viol         (viol_w),
      .bound        (bound_w),
      .none_free    (nf_w),
      .line_flat    (line_flat),
      .irq_out      (irq_out)
   );

   always_comb begin
      cfg_rdata = '0;
      for (int r = 0; r < N_REGIONS; r++) begin
         if (hit && sel == RIDX_W'(r)) begin
            case (word)
               W_CTRL: cfg_rdata = {30'd0, viol_w[r], busy_q[r]};
               W_BASE: cfg_rdata = 32'(base_flat[r*ADDR_W +: ADDR_W]);
               W_SIZE: cfg_rdata = 32'(size_flat[r*ADDR_W +: ADDR_W]);
               W_IRQ:  cfg_rdata = {20'd0, 4'(line_flat[r*LIW +: LIW]), 6'd0, nf_w[r], bound_w[r]};
               default: cfg_rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/region_ctrl_sva.sv
module region_ctrl_sva #(
   parameter int N   = 4,
   parameter int AW  = 32,
   parameter int LINES = 16,
   parameter int LIW = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N-1:0]       acc_req,
   input logic [N-1:0]       acc_err,
   input logic [N-1:0]       mem_req,
   input logic [N-1:0]       busy,
   input logic [N-1:0]       viol,
   input logic [N-1:0]       bound,
   input logic [N*LIW-1:0]   line_flat,
   input logic [N*AW-1:0]    base_flat,
   input logic [N*AW-1:0]    size_flat,
   input logic [LINES-1:0]   irq_out
);
   for (genvar r = 0; r < N; r++) begin : g_r
      assert_err_blocks_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
         acc_err[r] |-> !mem_req[r]);
      assert_err_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
         acc_err[r] |=> viol[r]);
      assert_window_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (busy[r] && $past(busy[r])) |-> ($stable(base_flat[r*AW +: AW]) && $stable(size_flat[r*AW +: AW])));
      assert_pass_needs_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
         mem_req[r] |-> (acc_req[r] && busy[r]));
   end

   for (genvar l = 0; l < LINES; l++) begin : g_l
      logic [N-1:0] owners;
      always_comb
         for (int r = 0; r < N; r++)
            owners[r] = bound[r] && (line_flat[r*LIW +: LIW] == LIW'(l));
      assert_line_unique_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(owners));
   end

   assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_out) |-> (|(viol & bound)));
endmodule

bind region_ctrl region_ctrl_sva #(.N(N_REGIONS), .AW(ADDR_W), .LINES(IRQ_LINES), .LIW(LIW)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_req   (acc_req),
   .acc_err   (acc_err),
   .mem_req   (mem_req),
   .busy      (busy_q),
   .viol      (viol_w),
   .bound     (bound_w),
   .line_flat (line_flat),
   .base_flat (base_flat),
   .size_flat (size_flat),
   .irq_out   (irq_out)
);

// File: tb/region_ctrl_test.sv
`timescale 1ns/1ps
module region_ctrl_test;
   localparam int N  = 4;
   localparam int AW = 32;
   localparam int LW = 4;
   localparam int BB = 4;
   localparam int NL = 3;
   localparam int CAW = 14;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_wr = 1'b0;
   logic [CAW-1:0] cfg_addr = '0;
   logic [31:0]    cfg_wdata = '0;
   logic [31:0]    cfg_rdata;
   logic [N-1:0]   acc_req = '0;
   logic [N*AW-1:0] acc_addr = '0;
   logic [N*LW-1:0] acc_len = '0;
   logic [N-1:0]   acc_gnt, acc_err, mem_req, mem_gnt;
   logic [N*AW-1:0] mem_addr;
   logic [N*LW-1:0] mem_len;
   logic [NL-1:0]  irq_out;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;
   assign mem_gnt = mem_req;

   region_ctrl #(.N_REGIONS(N), .ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB), .IRQ_LINES(NL)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .acc_req(acc_req), .acc_addr(acc_addr), .acc_len(acc_len),
      .acc_gnt(acc_gnt), .acc_err(acc_err), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_len(mem_len), .mem_gnt(mem_gnt), .irq_out(irq_out));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [CAW-1:0] adr(int r, int w);
      return {r[1:0], 7'd0, w[2:0], 2'b00};
   endfunction

   task automatic wr(int r, int w, logic [31:0] d);
      @(negedge clk);
      cfg_addr = adr(r, w); cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(int r, int w, output logic [31:0] d);
      cfg_addr = adr(r, w);
      #1 d = cfg_rdata;
   endtask

   task automatic try(int r, logic [31:0] a, int len, output logic ok, output logic er, output logic gn);
      @(negedge clk);
      acc_req[r] = 1'b1; acc_addr[r*AW +: AW] = a; acc_len[r*LW +: LW] = LW'(len);
      #1 ok = mem_req[r]; er = acc_err[r]; gn = acc_gnt[r];
      @(negedge clk);
      acc_req[r] = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int r = 0; r < N; r++) begin
         rd(r, 0, d); check("R2 status", d, 0);
         rd(r, 1, d); check("R2 base", d, 0);
         rd(r, 3, d); check("R2 irq reg", d, 0);
      end
      check("R2 irq_out", 32'(irq_out), 0);
   endtask

   task automatic t_states();
      logic [31:0] d;
      wr(2, 0, 32'h1); rd(2, 0, d); check("R3 start", d, 1);
      wr(2, 0, 32'h3); rd(2, 0, d); check("R3 finish wins", d, 0);
   endtask

   task automatic t_window();
      logic [31:0] d; logic ok, er, gn;
      wr(0, 1, 32'h1000); wr(0, 2, 32'h100);
      rd(0, 1, d); check("R1 base r0", d, 32'h1000);
      rd(1, 1, d); check("R1 base r1 untouched", d, 0);
      try(0, 32'h1000, 0, ok, er, gn); check("R5 idle refused", {ok, er}, 2'b01);
      wr(0, 2, 32'h100); wr(0, 0, 32'h4); wr(0, 0, 32'h1);
      wr(0, 1, 32'h2000); rd(0, 1, d); check("R4 base frozen", d, 32'h1000);
      wr(0, 2, 32'h10); rd(0, 2, d); check("R4 size frozen", d, 32'h100);
      @(negedge clk);
      acc_req[0] = 1'b1; acc_addr[0 +: AW] = 32'h1040; acc_len[0 +: LW] = 4'd2;
      #1 check("R11 pass", {mem_req[0], acc_gnt[0], acc_err[0]}, 3'b110);
      check("R11 addr", mem_addr[0 +: AW], 32'h1040);
      check("R11 len", 32'(mem_len[0 +: LW]), 2);
      @(negedge clk); acc_req[0] = 1'b0;
      try(0, 32'h10F0, 3, ok, er, gn); check("R5 exact end", {ok, er}, 2'b10);
      rd(0, 0, d); check("R6 no flag on allowed", d, 1);
      try(0, 32'h10F0, 4, ok, er, gn); check("R5 burst crosses", {ok, er}, 2'b01);
      rd(0, 0, d); check("R6 flag set", d, 3);
      wr(0, 0, 32'h4); rd(0, 0, d); check("R6 flag cleared", d, 1);
      try(0, 32'h0FFC, 0, ok, er, gn); check("R5 below base", {ok, er}, 2'b01);
      wr(0, 0, 32'h6); rd(0, 0, d); check("R3 idle+clear", d, 0);
   endtask

   task automatic t_irq();
      logic [31:0] d; logic ok, er, gn;
      wr(0, 3, 1); rd(0, 3, d); check("R7 r0 line0", d, 32'h001);
      wr(1, 3, 1); rd(1, 3, d); check("R7 r1 line1", d, 32'h101);
      wr(2, 3, 1); rd(2, 3, d); check("R7 r2 line2", d, 32'h201);
      wr(3, 3, 1); rd(3, 3, d); check("R8 none free", d & 32'h3, 32'h2);
      wr(1, 3, 2); rd(1, 3, d); check("R9 release", d & 32'h3, 0);
      wr(3, 3, 1); rd(3, 3, d); check("R9 reuse line1", d, 32'h101);
      check("R10 quiet", 32'(irq_out), 0);
      try(0, 32'h0, 0, ok, er, gn);
      #1 check("R10 line0 raised", 32'(irq_out), 32'h1);
      wr(0, 0, 32'h4); #1 check("R10 line0 dropped", 32'(irq_out), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_states();
      t_window();
      t_irq();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule